// File: doc/BRIEF.md
# Peripheral Region Address Decoder

This block sits on the register bus between a single 32-bit master and a set of peripheral target agents. Every peripheral target owns a contiguous run of entries in a region table that is fixed by parameters. Each entry gives the region's offset from a shared interconnect base address, its length in bytes, and a mask of the access widths the region accepts.

For each request the decoder finds the region that holds the address, which must lie in the mapped window above the base. It checks the requested width against that region's mask. One cycle later it returns a response. A good response carries a one-hot select for the owning target, the global region index, the byte offset inside the region, and a flag that says whether the region is the target's own agent-register region. A bad response carries an error flag, and every other field is zero. The address decode is combinational. The response is registered on the request strobe.

Top module: `periph_region_decoder`

## Requirements
- R1: Each cycle with `req_valid_i` high produces `rsp_valid_o` high in the next cycle. When `rsp_valid_o` is low, and after reset, every response output is zero.
- R2: A request that hits region r, where r is owned by target t, and whose width is allowed gets a response with `rsp_sel_o` equal to 1<<t, `rsp_region_o` equal to r and `rsp_err_o` low.
- R3: On a good response, `rsp_offset_o` is the request address minus the base address minus the region's offset.
- R4: An address below the base, or one that lies 0xB4000 bytes or more above it, is answered with an error.
- R5: An address that lies inside the window but in no region is answered with an error. The first byte and the last byte of each region decode to that region.
- R6: The width code is 0 for byte, 1 for halfword and 2 for word. Mask bit 0 allows byte access, bit 1 allows halfword access and bit 2 allows word access. A width whose bit is clear in the hit region's mask is answered with an error.
- R7: Width code 3 is answered with an error in every region.
- R8: `rsp_agent_o` is high on a good response when the hit region is the owning target's agent-register region. That region is the target's first region plus its agent index.
- R9: An error response has `rsp_sel_o`, `rsp_region_o`, `rsp_offset_o` and `rsp_agent_o` all zero.
- R10: `rsp_sel_o` never has more than one bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe |
| req_addr_i | input | 32 | Absolute request address |
| req_size_i | input | 2 | Access width code (0 byte, 1 half, 2 word, 3 invalid) |
| rsp_valid_o | output | 1 | Response strobe, one cycle after the request |
| rsp_err_o | output | 1 | Bus error: unmapped address or width not allowed |
| rsp_sel_o | output | NUM_TARGETS | One-hot select of the owning target |
| rsp_region_o | output | IDX_W | Global index of the hit region |
| rsp_offset_o | output | OFFS_W | Byte offset inside the hit region |
| rsp_agent_o | output | 1 | Hit region holds the target's agent registers |

## Verification
The assertions assume that the parameter table holds regions that do not overlap. They also assume that every region lies inside the window and that every agent index is smaller than its target's region count. The default table keeps to all three. They further assume that request inputs change only away from the rising edge. The bench drives every input on the falling edge and samples on the next falling edge, after exactly one register stage. The stimulus covers the first byte, the last byte and the byte just past each region, with all four width codes. It also adds addresses below the base, addresses at and beyond the end of the window, and addresses in the gaps between regions.

// File: rtl/rd_pkg.sv
package rd_pkg;
  typedef enum logic [1:0] {
    ACC_BYTE = 2'd0,
    ACC_HALF = 2'd1,
    ACC_WORD = 2'd2,
    ACC_BAD  = 2'd3
  } acc_size_e;

  localparam logic [2:0] WM_BYTE = 3'b001;
  localparam logic [2:0] WM_HALF = 3'b010;
  localparam logic [2:0] WM_WORD = 3'b100;
  localparam logic [2:0] WM_ALL  = WM_BYTE | WM_HALF | WM_WORD;
endpackage

// File: rtl/rd_region_match.sv
module rd_region_match #(
  parameter int unsigned NUM_REGIONS = 8,
  parameter int unsigned OFFS_W      = 12,
  parameter logic [31:0] BASE_ADDR   = 32'h4800_0000,
  parameter logic [31:0] WINDOW      = 32'h000B_4000,
  parameter logic [31:0] REG_OFFSET [NUM_REGIONS] = '{default: 32'h0},
  parameter logic [31:0] REG_SIZE   [NUM_REGIONS] = '{default: 32'h0}
) (
  input  logic [31:0]            addr_i,
  output logic [NUM_REGIONS-1:0] hit_o,
  output logic [OFFS_W-1:0]      rel_lo_o
);
  logic [31:0] rel;
  logic        in_win;

  assign rel      = addr_i - BASE_ADDR;
  assign in_win   = (addr_i >= BASE_ADDR) && (rel < WINDOW);
  assign rel_lo_o = rel[OFFS_W-1:0];

  for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_cmp
    assign hit_o[r] = in_win && (rel >= REG_OFFSET[r]) &&
                      (rel < REG_OFFSET[r] + REG_SIZE[r]);
  end
endmodule

// File: rtl/rd_width_check.sv
module rd_width_check #(
  parameter int unsigned NUM_REGIONS = 8,
  parameter logic [2:0]  REG_WMASK [NUM_REGIONS] = '{default: 3'b100}
) (
  input  logic [NUM_REGIONS-1:0] hit_i,
  input  logic [1:0]             size_i,
  output logic                   ok_o
);
  import rd_pkg::*;

  logic [NUM_REGIONS-1:0] allow;

  always_comb begin
    for (int r = 0; r < NUM_REGIONS; r++) begin
      unique case (size_i)
        ACC_BYTE: allow[r] = REG_WMASK[r][0];
        ACC_HALF: allow[r] = REG_WMASK[r][1];
        ACC_WORD: allow[r] = REG_WMASK[r][2];
        default:  allow[r] = 1'b0;
      endcase
    end
  end

  assign ok_o = |(hit_i & allow);
endmodule

// File: rtl/rd_target_map.sv
module rd_target_map #(
  parameter int unsigned NUM_REGIONS = 8,
  parameter int unsigned NUM_TARGETS = 4,
  parameter int unsigned TGT_FIRST [NUM_TARGETS] = '{default: 0},
  parameter int unsigned TGT_COUNT [NUM_TARGETS] = '{default: 1},
  parameter int unsigned TGT_AGENT [NUM_TARGETS] = '{default: 0}
) (
  input  logic [NUM_REGIONS-1:0] hit_i,
  output logic [NUM_TARGETS-1:0] sel_o,
  output logic                   agent_o
);
  logic [NUM_TARGETS-1:0] agent_t;

  for (genvar t = 0; t < NUM_TARGETS; t++) begin : g_tgt
    if (TGT_AGENT[t] >= TGT_COUNT[t]) begin : g_bad_cfg
      $error("agent index outside the target's region group");
    end
    logic [NUM_REGIONS-1:0] own;
    for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_own
      assign own[r] = (r >= TGT_FIRST[t]) && (r < TGT_FIRST[t] + TGT_COUNT[t]);
    end
    assign sel_o[t]   = |(hit_i & own);
    assign agent_t[t] = hit_i[TGT_FIRST[t] + TGT_AGENT[t]];
  end

  assign agent_o = |agent_t;
endmodule

// File: rtl/periph_region_decoder.sv
module periph_region_decoder
  import rd_pkg::*;
#(
  parameter int unsigned NUM_REGIONS      = 8,
  parameter int unsigned NUM_TARGETS      = 4,
  parameter int unsigned MAX_REGION_BYTES = 4096,
  parameter logic [31:0] BASE_ADDR        = 32'h4800_0000,
  parameter logic [31:0] WINDOW           = 32'h000B_4000,
  parameter logic [31:0] REG_OFFSET [NUM_REGIONS] = '{
    32'h4_0000, 32'h4_0800, 32'h4_1000, 32'h4_8000,
    32'h4_9000, 32'h6_E000, 32'h6_F000, 32'hB_3000},
  parameter logic [31:0] REG_SIZE [NUM_REGIONS] = '{
    32'h800, 32'h800, 32'h1000, 32'h1000,
    32'h800, 32'h1000, 32'h1000, 32'h1000},
  parameter logic [2:0] REG_WMASK [NUM_REGIONS] = '{
    WM_WORD, WM_WORD, WM_WORD, WM_ALL,
    WM_ALL, WM_WORD | WM_HALF, WM_WORD, WM_ALL},
  parameter int unsigned TGT_FIRST [NUM_TARGETS] = '{0, 3, 5, 7},
  parameter int unsigned TGT_COUNT [NUM_TARGETS] = '{3, 2, 2, 1},
  parameter int unsigned TGT_AGENT [NUM_TARGETS] = '{2, 1, 1, 0},
  localparam int unsigned IDX_W  = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1,
  localparam int unsigned OFFS_W = $clog2(MAX_REGION_BYTES)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   req_valid_i,
  input  logic [31:0]            req_addr_i,
  input  logic [1:0]             req_size_i,
  output logic                   rsp_valid_o,
  output logic                   rsp_err_o,
  output logic [NUM_TARGETS-1:0] rsp_sel_o,
  output logic [IDX_W-1:0]       rsp_region_o,
  output logic [OFFS_W-1:0]      rsp_offset_o,
  output logic                   rsp_agent_o
);
  logic [NUM_REGIONS-1:0] hit;
  logic [OFFS_W-1:0]      rel_lo;
  logic                   width_ok;
  logic [NUM_TARGETS-1:0] sel_c;
  logic                   agent_c;
  logic [IDX_W-1:0]       idx_c;
  logic [OFFS_W-1:0]      offs_c;
  logic                   err_c;

  rd_region_match #(
    .NUM_REGIONS(NUM_REGIONS), .OFFS_W(OFFS_W),
    .BASE_ADDR(BASE_ADDR), .WINDOW(WINDOW),
    .REG_OFFSET(REG_OFFSET), .REG_SIZE(REG_SIZE)
  ) u_match (
    .addr_i  (req_addr_i),
    .hit_o   (hit),
    .rel_lo_o(rel_lo)
  );

  rd_width_check #(
    .NUM_REGIONS(NUM_REGIONS), .REG_WMASK(REG_WMASK)
  ) u_width (
    .hit_i (hit),
    .size_i(req_size_i),
    .ok_o  (width_ok)
  );

  rd_target_map #(
    .NUM_REGIONS(NUM_REGIONS), .NUM_TARGETS(NUM_TARGETS),
    .TGT_FIRST(TGT_FIRST), .TGT_COUNT(TGT_COUNT), .TGT_AGENT(TGT_AGENT)
  ) u_tmap (
    .hit_i  (hit),
    .sel_o  (sel_c),
    .agent_o(agent_c)
  );

  // lowest hit wins; regions are disjoint so at most one hits
  always_comb begin
    idx_c  = '0;
    offs_c = '0;
    for (int r = NUM_REGIONS - 1; r >= 0; r--) begin
      if (hit[r]) begin
        idx_c  = IDX_W'(r);
        offs_c = rel_lo - REG_OFFSET[r][OFFS_W-1:0];
      end
    end
  end

  // unowned regions count as unmapped
  assign err_c = !width_ok || (sel_c == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o  <= 1'b0;
      rsp_err_o    <= 1'b0;
      rsp_sel_o    <= '0;
      rsp_region_o <= '0;
      rsp_offset_o <= '0;
      rsp_agent_o  <= 1'b0;
    end else begin
      rsp_valid_o <= req_valid_i;
      rsp_err_o   <= req_valid_i && err_c;
      if (req_valid_i && !err_c) begin
        rsp_sel_o    <= sel_c;
        rsp_region_o <= idx_c;
        rsp_offset_o <= offs_c;
        rsp_agent_o  <= agent_c;
      end else begin
        rsp_sel_o    <= '0;
        rsp_region_o <= '0;
        rsp_offset_o <= '0;
        rsp_agent_o  <= 1'b0;
      end
    end
  end

  p_rsp_follows_req_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);

  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsp_valid_o |-> (rsp_sel_o == '0 && !rsp_err_o && !rsp_agent_o));

  p_good_has_sel_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_err_o) |-> ($countones(rsp_sel_o) == 1));

  p_err_clean_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_err_o |-> (rsp_sel_o == '0 && rsp_offset_o == '0 &&
                   rsp_region_o == '0 && !rsp_agent_o));

  p_agent_in_sel_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_agent_o |-> ($countones(rsp_sel_o) == 1));

  p_sel_onehot_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(rsp_sel_o));

  p_bad_size_err_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_size_i == ACC_BAD) |=> rsp_err_o);
endmodule

// File: tb/periph_region_decoder_tb.sv
`timescale 1ns/1ps
module periph_region_decoder_tb_top;
  localparam int NR = 8;
  localparam int NT = 4;
  localparam logic [31:0] BASE = 32'h4800_0000;
  localparam logic [31:0] WIN  = 32'h000B_4000;
  localparam logic [31:0] M_OFF [NR] = '{32'h4_0000, 32'h4_0800, 32'h4_1000, 32'h4_8000,
                                         32'h4_9000, 32'h6_E000, 32'h6_F000, 32'hB_3000};
  localparam logic [31:0] M_SZ  [NR] = '{32'h800, 32'h800, 32'h1000, 32'h1000,
                                         32'h800, 32'h1000, 32'h1000, 32'h1000};
  localparam logic [2:0]  M_MSK [NR] = '{3'b100, 3'b100, 3'b100, 3'b111,
                                         3'b111, 3'b110, 3'b100, 3'b111};
  localparam int M_FIRST [NT] = '{0, 3, 5, 7};
  localparam int M_CNT   [NT] = '{3, 2, 2, 1};
  localparam int M_AGT   [NT] = '{2, 1, 1, 0};

  typedef struct packed {
    logic [31:0] addr;
    logic [1:0]  size;
    logic        err;
    logic [1:0]  tgt;
    logic [2:0]  region;
    logic [11:0] off;
    logic        agent;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{BASE + 32'h4_0000, 2'd2, 1'b0, 2'd0, 3'd0, 12'h000, 1'b0},
    '{BASE + 32'h4_0000, 2'd0, 1'b1, 2'd0, 3'd0, 12'h000, 1'b0},
    '{BASE + 32'h4_1004, 2'd2, 1'b0, 2'd0, 3'd2, 12'h004, 1'b1},
    '{BASE + 32'h4_8010, 2'd1, 1'b0, 2'd1, 3'd3, 12'h010, 1'b0},
    '{BASE + 32'h4_9100, 2'd0, 1'b0, 2'd1, 3'd4, 12'h100, 1'b1},
    '{BASE + 32'h6_E002, 2'd0, 1'b1, 2'd0, 3'd0, 12'h000, 1'b0},
    '{BASE + 32'h6_EFFE, 2'd1, 1'b0, 2'd2, 3'd5, 12'hFFE, 1'b0},
    '{BASE + 32'hB_3FFF, 2'd0, 1'b0, 2'd3, 3'd7, 12'hFFF, 1'b1},
    '{BASE + 32'hB_4000, 2'd2, 1'b1, 2'd0, 3'd0, 12'h000, 1'b0},
    '{BASE - 32'h4,      2'd2, 1'b1, 2'd0, 3'd0, 12'h000, 1'b0},
    '{BASE + 32'h5_0000, 2'd2, 1'b1, 2'd0, 3'd0, 12'h000, 1'b0},
    '{BASE + 32'h4_8000, 2'd3, 1'b1, 2'd0, 3'd0, 12'h000, 1'b0},
    '{32'hFFFF_FFFC,     2'd2, 1'b1, 2'd0, 3'd0, 12'h000, 1'b0}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [31:0] req_addr_i = '0;
  logic [1:0]  req_size_i = '0;
  logic        rsp_valid_o, rsp_err_o, rsp_agent_o;
  logic [NT-1:0] rsp_sel_o;
  logic [2:0]  rsp_region_o;
  logic [11:0] rsp_offset_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  periph_region_decoder dut_i (
    .clk_i, .rst_ni, .req_valid_i, .req_addr_i, .req_size_i,
    .rsp_valid_o, .rsp_err_o, .rsp_sel_o, .rsp_region_o, .rsp_offset_o, .rsp_agent_o
  );

  function automatic vec_t model(input logic [31:0] a, input logic [1:0] s);
    vec_t v;
    logic [31:0] rel;
    int hit;
    v = '0; v.addr = a; v.size = s; v.err = 1'b1;
    rel = a - BASE;
    hit = -1;
    if (a >= BASE && rel < WIN)
      for (int i = 0; i < NR; i++)
        if (rel >= M_OFF[i] && rel < M_OFF[i] + M_SZ[i]) hit = i;
    if (hit >= 0 && s != 2'd3 && M_MSK[hit][s]) begin
      v.err = 1'b0;
      v.region = 3'(hit);
      v.off = 12'(rel - M_OFF[hit]);
      for (int t = 0; t < NT; t++)
        if (hit >= M_FIRST[t] && hit < M_FIRST[t] + M_CNT[t]) begin
          v.tgt = 2'(t);
          v.agent = (hit == M_FIRST[t] + M_AGT[t]);
        end
    end
    return v;
  endfunction

  task automatic check(input string req, input vec_t e);
    logic [NT-1:0] esel;
    esel = e.err ? '0 : (NT'(1) << e.tgt);
    total++;
    if (rsp_valid_o !== 1'b1 || rsp_err_o !== e.err || rsp_sel_o !== esel ||
        rsp_region_o !== e.region || rsp_offset_o !== e.off || rsp_agent_o !== e.agent) begin
      bad++;
      $display("FAIL %s addr=%h size=%0d: got v=%b err=%b sel=%b reg=%0d off=%h ag=%b exp err=%b sel=%b reg=%0d off=%h ag=%b",
               req, e.addr, e.size, rsp_valid_o, rsp_err_o, rsp_sel_o, rsp_region_o,
               rsp_offset_o, rsp_agent_o, e.err, esel, e.region, e.off, e.agent);
    end
  endtask

  task automatic check_idle(input string req);
    total++;
    if (rsp_valid_o !== 1'b0 || rsp_err_o !== 1'b0 || rsp_sel_o !== '0 ||
        rsp_region_o !== '0 || rsp_offset_o !== '0 || rsp_agent_o !== 1'b0) begin
      bad++;
      $display("FAIL %s: got v=%b err=%b sel=%b reg=%0d off=%h ag=%b exp all zero",
               req, rsp_valid_o, rsp_err_o, rsp_sel_o, rsp_region_o, rsp_offset_o, rsp_agent_o);
    end
  endtask

  // drive on falling edge, response registered at the next rising edge
  task automatic apply(input string req, input vec_t e);
    @(negedge clk_i);
    req_valid_i = 1'b1;
    req_addr_i  = e.addr;
    req_size_i  = e.size;
    @(negedge clk_i);
    check(req, e);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check_idle("R1 reset state");
    rst_ni = 1'b1;
    @(negedge clk_i);
    check_idle("R1 idle after reset");

    // R2 R3 R4 R5 R6 R7 R8 R9 directed vectors
    for (int i = 0; i < NV; i++) apply("R2/R3/R4/R5/R6/R7/R8/R9 vector", VECS[i]);

    // first byte, last byte and one past each region, every width code
    for (int r = 0; r < NR; r++)
      for (int s = 0; s < 4; s++) begin
        apply("R5 first byte", model(BASE + M_OFF[r], 2'(s)));
        apply("R3 last byte", model(BASE + M_OFF[r] + M_SZ[r] - 1, 2'(s)));
        apply("R4 past region", model(BASE + M_OFF[r] + M_SZ[r], 2'(s)));
      end

    @(negedge clk_i);
    req_valid_i = 1'b0;
    @(negedge clk_i);
    check_idle("R1 idle after requests");

    // async reset in the middle of a good response
    apply("R2 before reset", VECS[2]);
    #2 rst_ni = 1'b0;
    #1 check_idle("R1 async reset clears");
    req_valid_i = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check_idle("R1 idle after second reset");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule